// File: doc/BRIEF.md
# Register Access Frame Engine for a Serial Sensor

This block is the master side of register traffic to a sensor that speaks in fixed 32-bit full-duplex serial frames. A client hands it one request at a time: a read or a write, 16 or 32 bits wide, with a 7-bit register address. The block builds the outgoing frames and shifts them out, most significant bit first. It sends the extra frame that is needed because the sensor answers each frame only during the frame after it. It then validates every reply it keeps and finishes with a one-cycle completion pulse.

Each frame carries a 4-bit check code. The code starts at binary 1010 and is XORed with every nibble above it. Each reply also carries a 2-bit health field. A reply is trusted only when its check code matches and its health field reads below 2. For writes the sensor echoes the written half-word back. A mismatch is reported unless the target is the command register, whose contents do not read back. Chip select is released between the frames of one access for a gap that software can set.

Top module: `spi_reg_codec`

## Requirements
- R1: Every frame is 32 bits, shifted out on `mosi` most significant bit first. `sclk` is low while `csN` is high. `mosi` changes after a falling `sclk` edge and `miso` is sampled on the rising edge. The frame fields are: bits 31:16 data, bit 15 zero, bits 14:8 register address, bit 7 write flag (1 = write), bits 6:4 zero, bits 3:0 check code.
- R2: The check code in bits 3:0 equals 4'hA XORed with each of the seven nibbles in bits 31:4.
- R3: In a read frame, the data field (bits 31:16) and the write flag (bit 7) are zero.
- R4: A 16-bit access sends two identical frames for the base address. A 32-bit access sends three frames in this order: the upper half (data bits 31:16) at address+1, the lower half at the base address, and that lower frame again.
- R5: `csN` is high whenever `reqReady` is high. Between two frames of one access, `csN` stays high for exactly `gapCycles`+2 clock cycles. `gapCycles` is sampled when the request is accepted.
- R6: The reply arriving during the first frame of an access is ignored. For a 32-bit access, the reply during the second frame fills `doneData[31:16]` and the reply during the third frame fills `doneData[15:0]`. For a 16-bit access, the reply during the second frame fills `doneData[15:0]` and `doneData[31:16]` is zero. The data taken from a reply is its bits 31:16. For writes this is the echoed data.
- R7: A kept reply whose bits 3:0 differ from the check code recomputed over its bits 31:4 raises `doneCrcErr`. Its half of `doneData` becomes zero and no other check applies to it.
- R8: A kept reply with a correct check code and a health field (bits 7:6) of 2 or 3 raises `doneStateErr`, and its half of `doneData` becomes zero. The values 0 and 1 are accepted.
- R9: For a write, a trusted reply whose data differs from the half-word written in that frame raises `doneVerifyErr`. This check is skipped when the base address is 7'h50, the command register.
- R10: `reqReady` is high only while idle, and a request is accepted when `reqValid` and `reqReady` are both high. Each accepted request yields exactly one single-cycle `doneValid` pulse. `reqReady` is high again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gapCycles | input | 8 | Chip-select high time between frames, minus two |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request may be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| reqAddr | input | 7 | Base register address |
| reqData | input | 32 | Write data (lower 16 bits used for 16-bit writes) |
| doneValid | output | 1 | Single-cycle completion pulse |
| doneData | output | 32 | Read data or echoed write data |
| doneCrcErr | output | 1 | A kept reply failed its check code |
| doneStateErr | output | 1 | A kept reply reported a bad health field |
| doneVerifyErr | output | 1 | Write echo did not match |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |

## Verification
The hardest case to reach from the ports is a reply that must be thrown away, namely the one returned during the first frame of every access. A sensor that behaves well never makes that discard visible. The bench's sensor model therefore sends an all-ones word, with a failing check code and health field, in the first frame of every access, so any use of that reply shows up as an error flag. The command-register exemption is similarly invisible unless the echo really differs. The model thus returns zero for command writes and can also flip echo bits on request, so the engine must tell an exempt mismatch from a reportable one.

// File: rtl/spi_codec_pkg.sv
package spi_codec_pkg;

  localparam int FRAME_W = 32;
  localparam int HALF_W  = 16;
  localparam int ADDR_W  = 7;
  localparam int CODE_W  = 4;
  localparam int NIBBLES = FRAME_W / CODE_W;

  // Strobes issued by the sequencer towards the datapath.
  typedef struct packed {
    logic accept;    // latch the request, clear result accumulators
    logic launch;    // start shifting one frame
    logic selUpper;  // frame being launched carries the upper half
    logic capUpper;  // store finished reply into the upper result half
    logic capLower;  // store finished reply into the lower result half
  } codecStrobe_t;

  // Check code: seed 1010, folded with every nibble above the code field.
  function automatic logic [CODE_W-1:0] frameCode(input logic [FRAME_W-1:0] word);
    logic [CODE_W-1:0] acc;
    acc = 4'hA;
    for (int n = NIBBLES - 1; n >= 1; n--) begin
      acc = acc ^ word[n*CODE_W +: CODE_W];
    end
    return acc;
  endfunction

  function automatic logic [FRAME_W-1:0] buildFrame(input logic [ADDR_W-1:0] regAddr,
                                                     input logic [HALF_W-1:0] payload,
                                                     input logic              isWrite);
    logic [FRAME_W-1:0] word;
    word = '0;
    word[FRAME_W-1 -: HALF_W] = isWrite ? payload : '0;
    word[8 +: ADDR_W]         = regAddr;
    word[7]                   = isWrite;
    word[CODE_W-1:0]          = frameCode(word);
    return word;
  endfunction

endpackage

// File: rtl/spi_codec_shifter.sv
module spi_codec_shifter
  import spi_codec_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               launch,
  input  logic [FRAME_W-1:0] txWord,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               csN,
  output logic               frameDone,
  output logic [FRAME_W-1:0] rxWord
);

  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic               busy;
  logic               sclkQ;
  logic               doneQ;
  logic [CNT_W-1:0]   phaseCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic [FRAME_W-1:0] txSh;
  logic [FRAME_W-1:0] rxSh;
  logic               phaseEnd;

  assign phaseEnd = (phaseCnt == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sclkQ    <= 1'b0;
      doneQ    <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
    end else begin
      doneQ <= 1'b0;
      if (launch && !busy) begin
        busy     <= 1'b1;
        txSh     <= txWord;
        phaseCnt <= '0;
        bitIdx   <= '0;
        sclkQ    <= 1'b0;
      end else if (busy) begin
        if (!phaseEnd) begin
          phaseCnt <= phaseCnt + 1'b1;
        end else begin
          phaseCnt <= '0;
          if (!sclkQ) begin
            sclkQ <= 1'b1;
            rxSh  <= {rxSh[FRAME_W-2:0], miso};
          end else begin
            sclkQ <= 1'b0;
            if (bitIdx == BIT_W'(FRAME_W - 1)) begin
              busy  <= 1'b0;
              doneQ <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              txSh   <= {txSh[FRAME_W-2:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign sclk      = sclkQ;
  assign mosi      = busy & txSh[FRAME_W-1];
  assign csN       = ~busy;
  assign frameDone = doneQ;
  assign rxWord    = rxSh;

endmodule

// File: rtl/spi_codec_dp.sv
module spi_codec_dp
  import spi_codec_pkg::*;
#(
  parameter int                HALF_CYC = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 7'h50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  codecStrobe_t          strb,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2*HALF_W-1:0]   reqData,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  csN,
  output logic                  frameDone,
  output logic [2*HALF_W-1:0]   doneData,
  output logic                  crcErr,
  output logic                  stateErr,
  output logic                  verifyErr
);

  logic                wrLat;
  logic [ADDR_W-1:0]   addrLat;
  logic [2*HALF_W-1:0] dataLat;
  logic [FRAME_W-1:0]  txWord;
  logic [FRAME_W-1:0]  rxWord;
  logic [ADDR_W-1:0]   frameAddr;
  logic [HALF_W-1:0]   framePayload;

  // Reply evaluation
  logic                capture;
  logic                codeOk;
  logic                healthBad;
  logic                trusted;
  logic [HALF_W-1:0]   replyData;
  logic [HALF_W-1:0]   sentHalf;
  logic                echoMismatch;
  logic [HALF_W-1:0]   keptHalf;
  logic [HALF_W-1:0]   upperAcc;
  logic [HALF_W-1:0]   lowerAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrLat   <= 1'b0;
      addrLat <= '0;
      dataLat <= '0;
    end else if (strb.accept) begin
      wrLat   <= reqWrite;
      addrLat <= reqAddr;
      dataLat <= reqData;
    end
  end

  assign frameAddr    = strb.selUpper ? addrLat + 1'b1 : addrLat;
  assign framePayload = strb.selUpper ? dataLat[2*HALF_W-1:HALF_W] : dataLat[HALF_W-1:0];
  assign txWord       = buildFrame(frameAddr, framePayload, wrLat);

  spi_codec_shifter #(
    .HALF_CYC(HALF_CYC)
  ) u_shifter (
    .clk      (clk),
    .rstN     (rstN),
    .launch   (strb.launch),
    .txWord   (txWord),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .csN      (csN),
    .frameDone(frameDone),
    .rxWord   (rxWord)
  );

  assign capture      = strb.capUpper | strb.capLower;
  assign codeOk       = (rxWord[CODE_W-1:0] == frameCode(rxWord));
  assign healthBad    = rxWord[7];               // health values 2 and 3
  assign trusted      = codeOk & ~healthBad;
  assign replyData    = rxWord[FRAME_W-1 -: HALF_W];
  assign sentHalf     = strb.capUpper ? dataLat[2*HALF_W-1:HALF_W] : dataLat[HALF_W-1:0];
  assign echoMismatch = wrLat && (addrLat != CMD_ADDR) && (replyData != sentHalf);
  assign keptHalf     = trusted ? replyData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperAcc  <= '0;
      lowerAcc  <= '0;
      crcErr    <= 1'b0;
      stateErr  <= 1'b0;
      verifyErr <= 1'b0;
    end else if (strb.accept) begin
      upperAcc  <= '0;
      lowerAcc  <= '0;
      crcErr    <= 1'b0;
      stateErr  <= 1'b0;
      verifyErr <= 1'b0;
    end else if (capture) begin
      if (strb.capUpper) upperAcc <= keptHalf;
      if (strb.capLower) lowerAcc <= keptHalf;
      if (!codeOk)                 crcErr    <= 1'b1;
      if (codeOk && healthBad)     stateErr  <= 1'b1;
      if (trusted && echoMismatch) verifyErr <= 1'b1;
    end
  end

  assign doneData = {upperAcc, lowerAcc};

endmodule

// File: rtl/spi_codec_ctrl.sv
module spi_codec_ctrl
  import spi_codec_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWide,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             frameDone,
  output logic             reqReady,
  output logic             doneValid,
  output codecStrobe_t     strb
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_SHIFT,
    ST_FINISH
  } seqState_t;

  seqState_t        state;
  logic [1:0]       frameIdx;
  logic [1:0]       lastIdx;
  logic             wideLat;
  logic [GAP_W-1:0] gapLat;
  logic [GAP_W-1:0] gapCnt;
  logic             gapOver;
  logic             upperReply;

  assign lastIdx    = wideLat ? 2'd2 : 2'd1;
  assign gapOver    = (gapCnt == gapLat);
  assign upperReply = wideLat && (frameIdx == 2'd1);

  always_comb begin
    strb          = '0;
    strb.accept   = (state == ST_IDLE) && reqValid;
    strb.launch   = (state == ST_GAP) && gapOver;
    strb.selUpper = wideLat && (frameIdx == 2'd0);
    if ((state == ST_SHIFT) && frameDone && (frameIdx != 2'd0)) begin
      strb.capUpper = upperReply;
      strb.capLower = !upperReply;
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign doneValid = (state == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      frameIdx <= '0;
      wideLat  <= 1'b0;
      gapLat   <= '0;
      gapCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            wideLat  <= reqWide;
            gapLat   <= gapCycles;
            gapCnt   <= gapCycles;   // first frame starts without a gap
            frameIdx <= '0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gapOver) state <= ST_SHIFT;
          else         gapCnt <= gapCnt + 1'b1;
        end
        ST_SHIFT: begin
          if (frameDone) begin
            if (frameIdx == lastIdx) begin
              state <= ST_FINISH;
            end else begin
              frameIdx <= frameIdx + 1'b1;
              gapCnt   <= '0;
              state    <= ST_GAP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_reg_codec.sv
module spi_reg_codec
  import spi_codec_pkg::*;
#(
  parameter int                SCLK_HALF = 2,
  parameter int                GAP_W     = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 7'h50
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [GAP_W-1:0]    gapCycles,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic                reqWide,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*HALF_W-1:0] reqData,
  output logic                doneValid,
  output logic [2*HALF_W-1:0] doneData,
  output logic                doneCrcErr,
  output logic                doneStateErr,
  output logic                doneVerifyErr,
  output logic                sclk,
  output logic                csN,
  output logic                mosi,
  input  logic                miso
);

  codecStrobe_t strb;
  logic         frameDone;

  spi_codec_ctrl #(
    .GAP_W(GAP_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWide  (reqWide),
    .gapCycles(gapCycles),
    .frameDone(frameDone),
    .reqReady (reqReady),
    .doneValid(doneValid),
    .strb     (strb)
  );

  spi_codec_dp #(
    .HALF_CYC(SCLK_HALF),
    .CMD_ADDR(CMD_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .csN      (csN),
    .frameDone(frameDone),
    .doneData (doneData),
    .crcErr   (doneCrcErr),
    .stateErr (doneStateErr),
    .verifyErr(doneVerifyErr)
  );

endmodule

// File: rtl/spi_reg_codec_chk.sv
module spi_reg_codec_chk #(
  parameter int         GAP_W    = 8,
  parameter logic [6:0] CMD_ADDR = 7'h50
) (
  input logic             clk,
  input logic             rstN,
  input logic [GAP_W-1:0] gapCycles,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic             reqWide,
  input logic [6:0]       reqAddr,
  input logic             doneValid,
  input logic [31:0]      doneData,
  input logic             doneVerifyErr,
  input logic             sclk,
  input logic             csN
);

  localparam int RUN_W = GAP_W + 2;

  logic             latWide;
  logic             latWrite;
  logic [6:0]       latAddr;
  logic [GAP_W-1:0] latGap;
  logic             seenFrame;
  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latWide   <= 1'b0;
      latWrite  <= 1'b0;
      latAddr   <= '0;
      latGap    <= '0;
      seenFrame <= 1'b0;
      hiRun     <= '0;
    end else begin
      if (reqValid && reqReady) begin
        latWide   <= reqWide;
        latWrite  <= reqWrite;
        latAddr   <= reqAddr;
        latGap    <= gapCycles;
        seenFrame <= 1'b0;
      end else if (!csN) begin
        seenFrame <= 1'b1;
      end
      if (!csN)            hiRun <= '0;
      else if (~&hiRun)    hiRun <= hiRun + 1'b1;
    end
  end

  // R1: serial clock rests low while the sensor is deselected
  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R5: chip select released whenever the engine is idle
  a_r5_cs_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);

  // R5: inter-frame gap length
  a_r5_gap_len: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && seenFrame && $fell(csN)) |-> (hiRun == RUN_W'(latGap) + RUN_W'(2)));

  // R6: narrow access leaves the upper half clear
  a_r6_narrow_upper: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !latWide) |-> (doneData[31:16] == 16'h0));

  // R9: command register writes never report an echo mismatch
  a_r9_cmd_exempt: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && latWrite && (latAddr == CMD_ADDR)) |-> !doneVerifyErr);

  // R10: completion is a single pulse followed by idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

  // R10: acceptance leaves the idle state
  a_r10_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind spi_reg_codec spi_reg_codec_chk #(
  .GAP_W   (GAP_W),
  .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .gapCycles    (gapCycles),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqWrite     (reqWrite),
  .reqWide      (reqWide),
  .reqAddr      (reqAddr),
  .doneValid    (doneValid),
  .doneData     (doneData),
  .doneVerifyErr(doneVerifyErr),
  .sclk         (sclk),
  .csN          (csN)
);

// File: tb/tb_spi_reg_codec.sv
module tb_spi_reg_codec;

  localparam int         CLK_PERIOD = 10;
  localparam logic [6:0] CMD        = 7'h50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  gapCycles = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqWide = 1'b0;
  logic [6:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        doneValid;
  logic [31:0] doneData;
  logic        doneCrcErr, doneStateErr, doneVerifyErr;
  logic        sclk, csN, mosi;
  logic        miso = 1'b0;

  spi_reg_codec dut (
    .clk(clk), .rstN(rstN), .gapCycles(gapCycles),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqData(reqData),
    .doneValid(doneValid), .doneData(doneData), .doneCrcErr(doneCrcErr),
    .doneStateErr(doneStateErr), .doneVerifyErr(doneVerifyErr),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] tbCode(input logic [31:0] w);
    logic [3:0] c = 4'b1010;
    for (int k = 28; k >= 4; k -= 4) c = c ^ w[k +: 4];
    return c;
  endfunction

  function automatic logic [31:0] mkFrame(input logic [6:0] a, input logic [15:0] d, input bit wr);
    logic [31:0] w;
    w = {wr ? d : 16'h0, 1'b0, a, wr, 7'b0};
    w[3:0] = tbCode(w);
    return w;
  endfunction

  // ---------------- sensor model ----------------
  logic [15:0] regs [128];
  logic [31:0] expFrames[$];
  logic [31:0] rxF, txF, nextReply;
  int          bitN, frameIdx;
  bit          armed, crcBad, echoBad;
  logic [1:0]  svVal = 2'd1;

  always @(negedge csN) begin
    if (rstN) begin
      armed = 1;
      bitN  = 0;
      txF   = (frameIdx == 0) ? 32'hFFFF_FFFF : nextReply;   // first reply is garbage
      miso  = txF[31];
    end
  end

  always @(posedge sclk) rxF = {rxF[30:0], mosi};

  always @(negedge sclk) begin
    if (!csN) begin
      bitN++;
      if (bitN < 32) miso = txF[31 - bitN];
    end
  end

  always @(posedge csN) begin
    if (armed) begin
      logic [31:0] want;
      logic [6:0]  a;
      logic [15:0] echo;
      armed = 0;
      if (expFrames.size() == 0) begin
        check(0, "R4 unexpected frame", rxF, 32'h0);
      end else begin
        want = expFrames.pop_front();
        check(rxF == want, "R1 R2 R3 R4 frame content", rxF, want);
      end
      a = rxF[14:8];
      if (rxF[7]) begin
        if (a != CMD) regs[a] = rxF[31:16];
        echo = (a == CMD) ? 16'h0 : rxF[31:16];
        if (echoBad) echo = echo ^ 16'h0001;
      end else begin
        echo = regs[a];
      end
      nextReply = {echo, 1'b0, a, svVal, 6'b0};
      nextReply[3:0] = tbCode(nextReply) ^ (crcBad ? 4'h1 : 4'h0);
      frameIdx++;
    end
  end

  // ---------------- per-clock comparison ----------------
  bit          pending = 0;
  logic [31:0] expData;
  bit          expC, expS, expV;
  int          expFrameCnt, gapCur, hiRun;
  logic        lastCs = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (reqReady && !csN) check(0, "R5 csN low while idle", {31'b0, csN}, 32'h1);
      if (csN && sclk)      check(0, "R1 sclk high while deselected", {31'b0, sclk}, 32'h0);
      if (csN) hiRun++;
      else begin
        if (lastCs && frameIdx > 0 && pending)
          check(hiRun == gapCur + 2, "R5 gap length", hiRun, gapCur + 2);
        hiRun = 0;
      end
      lastCs = csN;
      if (doneValid) begin
        if (!pending) check(0, "R10 spurious done", 32'h1, 32'h0);
        else begin
          check(doneData == expData, "R6 done data", doneData, expData);
          check(doneCrcErr == expC, "R7 check code flag", {31'b0, doneCrcErr}, {31'b0, expC});
          check(doneStateErr == expS, "R8 health flag", {31'b0, doneStateErr}, {31'b0, expS});
          check(doneVerifyErr == expV, "R9 verify flag", {31'b0, doneVerifyErr}, {31'b0, expV});
          check(frameIdx == expFrameCnt, "R4 frame count", frameIdx, expFrameCnt);
          pending = 0;
        end
      end
    end
  end

  task automatic doAccess(input bit wr, input bit wide, input logic [6:0] a,
                          input logic [31:0] d, input int gap);
    int wait_n = 0;
    expData = '0; expC = 0; expS = 0; expV = 0;
    for (int h = 0; h < (wide ? 2 : 1); h++) begin
      bit          up = wide && (h == 0);
      logic [6:0]  ah = up ? a + 7'd1 : a;
      logic [15:0] dh = up ? d[31:16] : d[15:0];
      logic [15:0] echo;
      if (wr) begin
        echo = (ah == CMD) ? 16'h0 : dh;
        if (echoBad) echo = echo ^ 16'h0001;
      end else echo = regs[ah];
      if (crcBad) expC = 1;
      else if (svVal >= 2) expS = 1;
      else begin
        if (up) expData[31:16] = echo; else expData[15:0] = echo;
        if (wr && a != CMD && echo != dh) expV = 1;
      end
      expFrames.push_back(mkFrame(ah, dh, wr));
    end
    expFrames.push_back(mkFrame(a, d[15:0], wr));   // collect frame
    expFrameCnt = wide ? 3 : 2;
    while (!reqReady) @(negedge clk);
    frameIdx = 0; gapCur = gap; hiRun = 0; pending = 1;
    reqValid = 1; reqWrite = wr; reqWide = wide; reqAddr = a; reqData = d;
    gapCycles = 8'(gap);
    @(negedge clk);
    reqValid = 0;
    while (pending && wait_n < 20000) begin @(negedge clk); wait_n++; end
    if (pending) begin
      check(0, "R10 no completion", 32'h0, 32'h1);
      pending = 0;
    end
    expFrames.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) regs[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
    frameIdx = 0;
    nextReply = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(reqReady == 1'b1, "R10 reset ready", {31'b0, reqReady}, 32'h1);
    check(csN == 1'b1, "R5 reset csN", {31'b0, csN}, 32'h1);
    check(sclk == 1'b0, "R1 reset sclk", {31'b0, sclk}, 32'h0);
    check(doneValid == 1'b0, "R10 reset done", {31'b0, doneValid}, 32'h0);

    // R4 R6 basic writes and reads with assorted gaps
    doAccess(1, 0, 7'h10, 32'h0000_1234, 0);
    doAccess(0, 0, 7'h10, 32'hFFFF_FFFF, 3);     // R3: read frames carry no data
    doAccess(1, 1, 7'h20, 32'hDEAD_BEEF, 1);
    doAccess(0, 1, 7'h20, 32'h0, 0);
    doAccess(0, 0, 7'h21, 32'h0, 2);
    svVal = 2'd0;                                 // R8: init state accepted
    doAccess(0, 0, 7'h05, 32'h0, 0);
    svVal = 2'd1;

    // R7 check code failures
    crcBad = 1;
    doAccess(0, 0, 7'h10, 32'h0, 1);
    doAccess(1, 1, 7'h40, 32'hCAFE_F00D, 0);
    crcBad = 0;

    // R8 health failures
    svVal = 2'd2;
    doAccess(0, 1, 7'h20, 32'h0, 0);
    svVal = 2'd3;
    doAccess(1, 0, 7'h12, 32'h0000_7777, 4);
    svVal = 2'd1;

    // R9 echo checks and command register exemption
    echoBad = 1;
    doAccess(1, 0, 7'h30, 32'h0000_00F0, 0);
    doAccess(1, 0, CMD, 32'h0000_8000, 0);
    doAccess(1, 1, CMD, 32'h1234_5678, 2);
    echoBad = 0;
    doAccess(1, 0, CMD, 32'h0000_0002, 0);

    // R6 stored data reads back
    doAccess(0, 1, 7'h40, 32'h0, 0);
    doAccess(0, 0, 7'h12, 32'h0, 7);
    doAccess(0, 0, 7'h7F, 32'h0, 0);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule